// File: doc/BRIEF.md
# Telemetry Frame Serializer

This block builds a fixed 60-bit telemetry frame from a set of sensor bytes and sends it, one bit at a time, to a radio transmitter module. A frame holds five 12-bit words. The first word is a constant sync pattern. It is followed by four data words, and each data word is an identifier nibble placed above an 8-bit sensor value. Three of the data slots carry sensor readings. The fourth slot is spare.

Operation is split by a slow refresh signal into two phases. While `load_phase` is high, the frame register is reloaded from the sensor inputs on every system clock. While `load_phase` is low, each `bit_en` pulse moves the register one place. The bit that leaves the top of the register is sent on `sdo` and is also fed back into the bottom. No bit counter is needed, and a register that has been fully shifted out holds the same frame it started with. The refresh period is chosen so that all 60 bits leave the register before the next load.

Top module: `telemetry_serializer`

## Requirements
- R1: During reset and just after it, `sdo` is 0.
- R2: Every frame is 60 bits long and is sent MSB-first. Frame bits 59..48 are the sync word 0x228, so the first twelve bits sent are 0010_0010_1000.
- R3: Data slot k is `sensor_data[8k+7:8k]`, for k = 0..3. It is sent as frame word k+1. That word's top nibble is the identifier k+1 (0x1..0x4) and its low byte is the slot value. Slot 0 follows the sync word directly.
- R4: While `load_phase` is high, the register is reloaded on every clock. The frame that is sent is the one built from the inputs present at the last clock edge of the load phase.
- R5: While `load_phase` is high, `bit_en` has no effect and `sdo` does not change.
- R6: While `load_phase` is low, each clock edge with `bit_en` high puts the next frame bit on `sdo` at that edge.
- R7: With `load_phase` low and `bit_en` low, `sdo` holds its value and the register does not move.
- R8: The register rotates. Shift 61 after a load sends frame bit 59 again, and the frame then repeats unchanged.
- R9: Changes on `sensor_data` during the shift phase do not alter the bits that are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_phase | input | 1 | Refresh phase: high = parallel load, low = shift |
| bit_en | input | 1 | Bit-rate enable, one system-clock pulse per bit |
| sensor_data | input | 32 | Four 8-bit sensor slots, slot 0 in the low byte |
| sdo | output | 1 | Serial data to the transmitter |

## Verification
Assertions are checked on every cycle. They confirm that a load leaves the sync word at the top of the register, that `sdo` stays put whenever no shift is allowed, that each shift sends the previous top bit, and that rotation keeps the number of ones in the register the same. Only the bench scenarios can show the full frame order bit by bit: identifier placement, which inputs get captured at the end of a load phase, wrap-around after 60 shifts, and indifference to inputs that change during shifting.

// File: rtl/telemetry_serializer.sv
module telemetry_serializer #(
  parameter int WORD_W = 12,
  parameter int ID_W   = 4,
  parameter int N_DATA = 4,
  parameter logic [WORD_W-1:0] SYNC_WORD = 12'h228
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               load_phase,
  input  logic                               bit_en,
  input  logic [N_DATA*(WORD_W-ID_W)-1:0]    sensor_data,
  output logic                               sdo
);
  localparam int DATA_W  = WORD_W - ID_W;
  localparam int FRAME_W = WORD_W * (N_DATA + 1);

  logic [FRAME_W-1:0] frame_word;
  logic [FRAME_W-1:0] shreg;
  logic               shift_now;

  assign frame_word[FRAME_W-1 -: WORD_W] = SYNC_WORD;

  for (genvar k = 0; k < N_DATA; k++) begin : g_slot
    assign frame_word[FRAME_W-1-(k+1)*WORD_W -: WORD_W] =
      {ID_W'(k + 1), sensor_data[k*DATA_W +: DATA_W]};
  end

  assign shift_now = !load_phase && bit_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      sdo   <= 1'b0;
    end else if (load_phase) begin
      shreg <= frame_word;
    end else if (bit_en) begin
      sdo   <= shreg[FRAME_W-1];
      shreg <= {shreg[FRAME_W-2:0], shreg[FRAME_W-1]};
    end
  end

  assert_sync_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase |=> shreg[FRAME_W-1 -: WORD_W] == SYNC_WORD);

  assert_hold_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_phase |=> $stable(sdo));

  assert_shift_emits_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shift_now |=> sdo == $past(shreg[FRAME_W-1]));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_phase && !bit_en) |=> ($stable(sdo) && $stable(shreg)));

  assert_rotate_keeps_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shift_now |=> $countones(shreg) == $past($countones(shreg)));
endmodule

// File: tb/sim_telemetry_serializer.sv
module sim_telemetry_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_phase = 1'b0;
  logic        bit_en = 1'b0;
  logic [31:0] sensor_data = '0;
  logic        sdo;

  int n_checks = 0;
  int n_fail = 0;
  int nshift = 0;
  logic [59:0] exp_frame = '0;

  telemetry_serializer u0 (
    .clk(clk), .rst_n(rst_n), .load_phase(load_phase),
    .bit_en(bit_en), .sensor_data(sensor_data), .sdo(sdo)
  );

  always #4 clk = ~clk;

  function automatic logic [59:0] mk_frame(input logic [31:0] d);
    return {12'h228, 4'h1, d[7:0], 4'h2, d[15:8], 4'h3, d[23:16], 4'h4, d[31:24]};
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic ok, input string req, input logic act, input logic exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: sdo actual %0b expected %0b (shift %0d)", req, act, exp, nshift);
    end
  endtask

  task automatic do_load(input logic [31:0] d, input int cycles);
    logic held;
    load_phase = 1'b1;
    held = sdo;
    for (int i = 0; i < cycles; i++) begin
      sensor_data = $urandom;
      bit_en = $urandom_range(0, 1);
      tick();
      check(sdo == held, "R5", sdo, held);
    end
    sensor_data = d;
    bit_en = 1'b1;
    tick();
    check(sdo == held, "R5", sdo, held);
    load_phase = 1'b0;
    bit_en = 1'b0;
    exp_frame = mk_frame(d);
    nshift = 0;
  endtask

  task automatic shift_one(input string req, input logic scramble);
    logic e;
    if (scramble) sensor_data = $urandom;
    bit_en = 1'b1;
    tick();
    bit_en = 1'b0;
    e = exp_frame[59 - (nshift % 60)];
    check(sdo == e, req, sdo, e);
    nshift++;
  endtask

  task automatic idle(input int n);
    logic held;
    held = sdo;
    for (int i = 0; i < n; i++) begin
      tick();
      check(sdo == held, "R7", sdo, held);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    tick(); tick();
    check(sdo == 1'b0, "R1", sdo, 1'b0);
    rst_n = 1'b1;
    tick();
    check(sdo == 1'b0, "R1", sdo, 1'b0);

    // directed frame: sync, ids and slot order
    do_load(32'h00FF_3CA5, 4);
    for (int i = 0; i < 12; i++) shift_one("R2", 1'b0);
    for (int i = 0; i < 48; i++) begin
      shift_one(i % 12 < 4 ? "R3" : "R6", 1'b0);
      if (i % 7 == 3) idle(3);
    end
    // wrap-around: frame repeats
    for (int i = 0; i < 14; i++) shift_one("R8", 1'b0);

    // last inputs of load phase win; inputs in shift phase ignored
    do_load(32'hC3_5A_0F_81, 9);
    for (int i = 0; i < 60; i++) shift_one("R9", 1'b1);
    for (int i = 0; i < 3; i++) shift_one("R8", 1'b1);

    // all ones / all zeros slots
    do_load(32'hFFFF_FFFF, 1);
    for (int i = 0; i < 60; i++) shift_one("R4", 1'b0);
    do_load(32'h0000_0000, 2);
    for (int i = 0; i < 60; i++) shift_one("R4", 1'b0);

    // random frames with random gaps and partial drains
    for (int f = 0; f < 20; f++) begin
      int n;
      do_load($urandom, $urandom_range(0, 6));
      n = $urandom_range(10, 75);
      for (int i = 0; i < n; i++) begin
        shift_one("R6", $urandom_range(0, 1) == 1);
        if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 4));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule